// File: doc/BRIEF.md
# Stack Pair Transfer Sequencer

This block carries out the stack-side half of a small 8-bit processor's stack instructions. It owns the 16-bit stack pointer and drives a single-port byte memory one access per clock. It moves a 16-bit register pair to the stack or back, swaps a pair with the top two stack bytes, loads the pointer from a pair, and saves or restores a return address around a subroutine call. Decoding and the ALU sit outside it. The core hands over a command code, a 16-bit pair value (and, for a call, the jump target), pulses `start` for one cycle and waits for `done`.

The memory read path is combinational. The byte at `mem_addr` must be valid on `mem_rdata` within the same cycle, and the block captures it at the closing clock edge. A write happens at the edge that ends a cycle in which `mem_we` is high. When the accumulator and the flag byte are handled as one pair, the flags travel in the low byte.

Top module: `stk_pair_seq`

## Requirements
- R1: A synchronous active-high reset sets `sp_out` to 0000h and `result` to 0000h, drops `done` and `mem_we`, and leaves the sequencer idle.
- R2: A push (cmd 000) performs two write cycles. It first writes the pair's high byte (operand[15:8]) at SP-1, then the low byte (operand[7:0]) at SP-2. It ends with SP lowered by 2 and `result` equal to the operand.
- R3: A pop (cmd 001) reads the low byte at SP and then the high byte at SP+1. It returns {high, low} on `result` and ends with SP raised by 2.
- R4: An exchange (cmd 010) takes four cycles in this order: read SP, write operand[7:0] at SP, read SP+1, write operand[15:8] at SP+1. `result` returns the old stack word {[SP+1],[SP]}, and SP is the same value before and after.
- R5: A pointer load (cmd 011) sets SP to the operand, with operand[15:8] as the upper address byte. It makes no memory write and finishes one cycle after acceptance.
- R6: A call (cmd 100) pushes the operand, taken as the return address, exactly as R2 does. It then places `target` on `result` as the new program counter.
- R7: A return (cmd 101) pops two bytes as in R3 and places them on `result` as the new program counter.
- R8: `done` is high for exactly one cycle. It rises N cycles after the accepting edge, where N is 2 for push, pop, call and return, 4 for exchange and 1 for a pointer load.
- R9: The block ignores a `start` that arrives while an operation is in progress, and a `start` carrying cmd 110 or 111. Neither one changes SP or memory, and neither produces `done`.
- R10: SP arithmetic wraps modulo 2^16. A push from 0000h writes at FFFFh and then at FFFEh, and a pop from FFFEh returns SP to 0000h.
- R11: When the accumulator pair {accumulator, flags} is pushed, the flag byte goes to the lower of the two addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request strobe |
| cmd | input | 3 | Command code (see R2 to R7) |
| operand | input | 16 | Register pair value, or return address for a call |
| target | input | 16 | Jump target for a call |
| mem_rdata | input | 8 | Byte read from the stack memory, same cycle |
| mem_addr | output | 16 | Stack memory byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_we | output | 1 | Write enable |
| sp_out | output | 16 | Current stack pointer |
| result | output | 16 | Pair value, program counter or loaded pointer from the last operation |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check, on every cycle, the pointer steps that follow each access. After a push write the pointer must equal the address just written. After a pop read it must sit one above that address. Throughout an exchange it must not move. The checker also confirms that writes occur only while an operation is in progress, that a pointer load never writes, that `done` lasts a single cycle, and that a second `start` cannot disturb an operation already under way. Byte order, the values returned on `result`, the exact latencies, wrap-around at the ends of the address space and the rejection of unused command codes depend on the data. Only the bench's scenarios show those, by comparing a memory model and the outputs against values worked out by hand.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [2:0] {
    CMD_PUSH = 3'd0,
    CMD_POP  = 3'd1,
    CMD_XCHG = 3'd2,
    CMD_LDSP = 3'd3,
    CMD_CALL = 3'd4,
    CMD_RET  = 3'd5
  } stk_cmd_e;

  localparam int STEP_W = 2;

  // Codes 6 and 7 are unused and must be rejected.
  function automatic logic cmd_known(logic [2:0] c);
    return c <= 3'd5;
  endfunction

  // Index of the final cycle of each operation.
  function automatic logic [STEP_W-1:0] final_step(stk_cmd_e c);
    case (c)
      CMD_XCHG: return STEP_W'(3);
      CMD_LDSP: return STEP_W'(0);
      default:  return STEP_W'(1);
    endcase
  endfunction

  function automatic logic is_pushlike(stk_cmd_e c);
    return (c == CMD_PUSH) || (c == CMD_CALL);
  endfunction

  function automatic logic is_poplike(stk_cmd_e c);
    return (c == CMD_POP) || (c == CMD_RET);
  endfunction

endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        cmd_in,
  output logic              busy,
  output logic [STEP_W-1:0] step,
  output stk_cmd_e          cur_cmd,
  output logic              accept,
  output logic              last,
  output logic              done
);

  assign accept = start && !busy && cmd_known(cmd_in);
  assign last   = busy && (step == final_step(cur_cmd));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      step    <= '0;
      cur_cmd <= CMD_PUSH;
      done    <= 1'b0;
    end else begin
      done <= last;
      if (accept) begin
        busy    <= 1'b1;
        step    <= '0;
        cur_cmd <= stk_cmd_e'(cmd_in);
      end else if (last) begin
        busy <= 1'b0;
        step <= '0;
      end else if (busy) begin
        step <= step + 1'b1;
      end
    end
  end

endmodule

// File: rtl/stk_addr_gen.sv
module stk_addr_gen
  import stk_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              busy,
  input  stk_cmd_e          cur_cmd,
  input  logic [STEP_W-1:0] step,
  input  logic [2*DW-1:0]   sp,
  input  logic [2*DW-1:0]   opnd,
  output logic [2*DW-1:0]   addr,
  output logic              we,
  output logic [DW-1:0]     wdata,
  output logic [2*DW-1:0]   sp_next
);

  localparam int AW = 2 * DW;

  function automatic logic [AW-1:0] ptr_up(logic [AW-1:0] p);
    return p + 1'b1;
  endfunction

  function automatic logic [AW-1:0] ptr_down(logic [AW-1:0] p);
    return p - 1'b1;
  endfunction

  logic [DW-1:0] hi_b, lo_b;
  assign hi_b = opnd[AW-1:DW];
  assign lo_b = opnd[DW-1:0];

  always_comb begin
    addr    = sp;
    we      = 1'b0;
    wdata   = '0;
    sp_next = sp;
    if (busy) begin
      if (is_pushlike(cur_cmd)) begin
        addr    = ptr_down(sp);
        we      = 1'b1;
        wdata   = (step == '0) ? hi_b : lo_b;
        sp_next = ptr_down(sp);
      end else if (is_poplike(cur_cmd)) begin
        addr    = sp;
        sp_next = ptr_up(sp);
      end else if (cur_cmd == CMD_XCHG) begin
        addr  = step[1] ? ptr_up(sp) : sp;
        we    = step[0];
        wdata = step[1] ? hi_b : lo_b;
      end else if (cur_cmd == CMD_LDSP) begin
        sp_next = opnd;
      end
    end
  end

endmodule

// File: rtl/stk_capture.sv
module stk_capture
  import stk_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  stk_cmd_e          cur_cmd,
  input  logic [STEP_W-1:0] step,
  input  logic              last,
  input  logic [DW-1:0]     rdata,
  input  logic [2*DW-1:0]   opnd,
  input  logic [2*DW-1:0]   tgt,
  output logic [2*DW-1:0]   result
);

  logic [DW-1:0] lo_q, hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q   <= '0;
      hi_q   <= '0;
      result <= '0;
    end else if (busy) begin
      if (is_poplike(cur_cmd)) begin
        if (step == '0) lo_q <= rdata;
        if (last) result <= {rdata, lo_q};
      end else if (cur_cmd == CMD_XCHG) begin
        if (step == STEP_W'(0)) lo_q <= rdata;
        if (step == STEP_W'(2)) hi_q <= rdata;
        if (last) result <= {hi_q, lo_q};
      end else if (cur_cmd == CMD_CALL) begin
        if (last) result <= tgt;
      end else begin
        if (last) result <= opnd;
      end
    end
  end

endmodule

// File: rtl/stk_pair_seq.sv
module stk_pair_seq
  import stk_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        cmd,
  input  logic [2*DW-1:0]   operand,
  input  logic [2*DW-1:0]   target,
  input  logic [DW-1:0]     mem_rdata,
  output logic [2*DW-1:0]   mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic              mem_we,
  output logic [2*DW-1:0]   sp_out,
  output logic [2*DW-1:0]   result,
  output logic              done
);

  localparam int AW = 2 * DW;

  logic              busy_w, accept_w, last_w;
  logic [STEP_W-1:0] step_w;
  stk_cmd_e          cur_cmd_w;
  logic [AW-1:0]     sp_q, sp_next_w, opnd_q, tgt_q;

  stk_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .cmd_in(cmd),
    .busy(busy_w), .step(step_w), .cur_cmd(cur_cmd_w),
    .accept(accept_w), .last(last_w), .done(done)
  );

  stk_addr_gen #(.DW(DW)) u_addr (
    .busy(busy_w), .cur_cmd(cur_cmd_w), .step(step_w), .sp(sp_q),
    .opnd(opnd_q), .addr(mem_addr), .we(mem_we), .wdata(mem_wdata),
    .sp_next(sp_next_w)
  );

  stk_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst(rst), .busy(busy_w), .cur_cmd(cur_cmd_w),
    .step(step_w), .last(last_w), .rdata(mem_rdata), .opnd(opnd_q),
    .tgt(tgt_q), .result(result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q   <= '0;
      opnd_q <= '0;
      tgt_q  <= '0;
    end else begin
      if (accept_w) begin
        opnd_q <= operand;
        tgt_q  <= target;
      end
      if (busy_w) sp_q <= sp_next_w;
    end
  end

  assign sp_out = sp_q;

endmodule

// File: rtl/stk_seq_chk.sv
module stk_seq_chk
  import stk_pkg::*;
#(
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            busy,
  input logic            last,
  input stk_cmd_e        cur_cmd,
  input logic            mem_we,
  input logic [2*DW-1:0] mem_addr,
  input logic [2*DW-1:0] sp_out,
  input logic            done
);

  localparam int AW = 2 * DW;

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (sp_out == '0) && !done && !mem_we);

  p_push_ptr_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_we && is_pushlike(cur_cmd)) |=> sp_out == $past(mem_addr));

  p_pop_ptr_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && is_poplike(cur_cmd)) |=> sp_out == AW'($past(mem_addr) + 1'b1));

  p_xchg_sp_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && cur_cmd == CMD_XCHG) |=> $stable(sp_out));

  p_ldsp_nowrite_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && cur_cmd == CMD_LDSP) |-> !mem_we);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_write_busy_r9: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  p_ignore_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !last) |=> busy && (cur_cmd == $past(cur_cmd)));

endmodule

bind stk_pair_seq stk_seq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy_w), .last(last_w),
  .cur_cmd(cur_cmd_w), .mem_we(mem_we), .mem_addr(mem_addr),
  .sp_out(sp_out), .done(done)
);

// File: tb/sim_stk_pair_seq.sv
module sim_stk_pair_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  cmd = 3'd0;
  logic [15:0] operand = '0, target = '0;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr, sp_out, result;
  logic [7:0]  mem_wdata;
  logic        mem_we, done;

  int n_cmp = 0, n_bad = 0;
  int wcount = 0, base = 0, lat = 0;

  logic [7:0]  mem [0:255];
  logic [15:0] wa  [0:15];
  logic [7:0]  wd  [0:15];

  always #2 clk = ~clk;

  stk_pair_seq u0 (
    .clk(clk), .rst(rst), .start(start), .cmd(cmd), .operand(operand),
    .target(target), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .sp_out(sp_out),
    .result(result), .done(done)
  );

  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr[7:0]] = mem_wdata;
      wa[wcount % 16] = mem_addr;
      wd[wcount % 16] = mem_wdata;
      wcount = wcount + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_wr(input string tag, input int idx, input logic [15:0] a, input logic [7:0] d);
    chk({tag, " write addr"}, 32'(wa[(base + idx) % 16]), 32'(a));
    chk({tag, " write data"}, 32'(wd[(base + idx) % 16]), 32'(d));
  endtask

  task automatic issue(input logic [2:0] c, input logic [15:0] op, input logic [15:0] tg);
    @(negedge clk);
    cmd = c; operand = op; target = tg; start = 1'b1; base = wcount;
    @(negedge clk);
    start = 1'b0; lat = 0;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    @(negedge clk);
    chk("R8 done width", 32'(done), 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 sp", 32'(sp_out), 32'h0);
    chk("R1 result", 32'(result), 32'h0);
    chk("R1 done", 32'(done), 32'h0);
    chk("R1 we", 32'(mem_we), 32'h0);
  endtask

  task automatic t_ldsp;
    issue(3'd3, 16'h1280, 16'h0);
    chk("R5 sp", 32'(sp_out), 32'h1280);
    chk("R5 result", 32'(result), 32'h1280);
    chk("R5 latency", 32'(lat), 32'd1);
    chk("R5 no write", 32'(wcount - base), 32'd0);
  endtask

  task automatic t_push;
    issue(3'd0, 16'hA1B2, 16'h0);
    chk("R8 push latency", 32'(lat), 32'd2);
    chk("R2 write count", 32'(wcount - base), 32'd2);
    chk_wr("R2 first", 0, 16'h127F, 8'hA1);
    chk_wr("R2 second", 1, 16'h127E, 8'hB2);
    chk("R2 sp", 32'(sp_out), 32'h127E);
    chk("R2 result", 32'(result), 32'hA1B2);
  endtask

  task automatic t_flags;
    issue(3'd0, 16'h3CD5, 16'h0);
    chk("R11 flags low addr", 32'(mem[8'h7C]), 32'hD5);
    chk("R11 acc high addr", 32'(mem[8'h7D]), 32'h3C);
  endtask

  task automatic t_pop;
    issue(3'd1, 16'h0, 16'h0);
    chk("R3 result", 32'(result), 32'h3CD5);
    chk("R3 sp", 32'(sp_out), 32'h127E);
    chk("R8 pop latency", 32'(lat), 32'd2);
    issue(3'd1, 16'h0, 16'h0);
    chk("R3 result 2", 32'(result), 32'hA1B2);
    chk("R3 sp 2", 32'(sp_out), 32'h1280);
    chk("R3 no write", 32'(wcount - base), 32'd0);
  endtask

  task automatic t_xchg;
    issue(3'd3, 16'h1240, 16'h0);
    mem[8'h40] = 8'h11;
    mem[8'h41] = 8'h22;
    issue(3'd2, 16'h5566, 16'h0);
    chk("R4 result", 32'(result), 32'h2211);
    chk("R4 sp", 32'(sp_out), 32'h1240);
    chk("R8 xchg latency", 32'(lat), 32'd4);
    chk("R4 write count", 32'(wcount - base), 32'd2);
    chk_wr("R4 low", 0, 16'h1240, 8'h66);
    chk_wr("R4 high", 1, 16'h1241, 8'h55);
  endtask

  task automatic t_call_ret;
    issue(3'd4, 16'h0345, 16'h0800);
    chk("R6 result", 32'(result), 32'h0800);
    chk("R6 sp", 32'(sp_out), 32'h123E);
    chk_wr("R6 first", 0, 16'h123F, 8'h03);
    chk_wr("R6 second", 1, 16'h123E, 8'h45);
    issue(3'd5, 16'h0, 16'h0);
    chk("R7 result", 32'(result), 32'h0345);
    chk("R7 sp", 32'(sp_out), 32'h1240);
    chk("R7 latency", 32'(lat), 32'd2);
  endtask

  task automatic t_ignore;
    int dn;
    @(negedge clk);
    cmd = 3'd2; operand = 16'h5566; start = 1'b1; base = wcount;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    cmd = 3'd3; operand = 16'h0000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dn = 0;
    for (int i = 0; i < 8; i++) begin
      if (done) dn++;
      @(negedge clk);
    end
    chk("R9 busy start done count", 32'(dn), 32'd1);
    chk("R9 busy start sp", 32'(sp_out), 32'h1240);
    chk("R9 busy start result", 32'(result), 32'h5566);
    @(negedge clk);
    cmd = 3'd6; operand = 16'h0000; start = 1'b1; base = wcount;
    @(negedge clk);
    start = 1'b0;
    dn = 0;
    for (int i = 0; i < 6; i++) begin
      if (done) dn++;
      @(negedge clk);
    end
    chk("R9 code 6 done", 32'(dn), 32'd0);
    chk("R9 code 6 sp", 32'(sp_out), 32'h1240);
    chk("R9 code 6 writes", 32'(wcount - base), 32'd0);
  endtask

  task automatic t_wrap;
    issue(3'd3, 16'h0000, 16'h0);
    issue(3'd0, 16'hBEEF, 16'h0);
    chk_wr("R10 first", 0, 16'hFFFF, 8'hBE);
    chk_wr("R10 second", 1, 16'hFFFE, 8'hEF);
    chk("R10 sp after push", 32'(sp_out), 32'hFFFE);
    issue(3'd1, 16'h0, 16'h0);
    chk("R10 pop result", 32'(result), 32'hBEEF);
    chk("R10 sp after pop", 32'(sp_out), 32'h0000);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_ldsp;
    t_push;
    t_flags;
    t_pop;
    t_xchg;
    t_call_ret;
    t_ignore;
    t_wrap;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule